// File: doc/BRIEF.md
# ISA-style expansion bus master

This block turns single internal read and write requests into 8-bit and 16-bit expansion bus cycles of the classic ISA kind. It reaches two spaces: a 64 kB I/O window and a 16 MB memory window. For each request it drives an address latch pulse, the address lines, the high-byte-enable line and one of four active-low strobes: I/O read, I/O write, memory read or memory write. It waits for as long as the target holds the ready line low, captures read data, and then returns it with a one-cycle done pulse. A free-running bus clock at one twelfth of the internal clock is also produced.

Every window can be reached through two aliases that address the same physical space. In the narrow alias, every byte travels on the low data lane. In the wide alias, even bytes use the low lane, odd bytes use the high lane, and a word access uses both lanes at once. The cycle has three timed phases: address with latch pulse, strobe, and hold. Each phase length is a parameter counted in internal clock cycles, and the timing is the same for byte and word accesses. The address-enable output stays low, since the block never gives up the bus.

Top module: `isa_bus_master`

## Requirements
- R1: While reset is high and after it: req_ready is 1, bale is 0, all four strobes are 1, sbhe_n is 1, rsp_done is 0, and both data output enables are 0.
- R2: bus_clk is a square wave with a period of CLK_DIV internal cycles (high CLK_DIV/2, low CLK_DIV/2). It starts low out of reset and first rises CLK_DIV/2 cycles after reset.
- R3: A request is accepted at a clock edge where req_valid and req_ready are both 1. In the next cycle bale goes to 1 and stays there for exactly T_SETUP cycles, with the address driven. No strobe is active while bale is 1.
- R4: After the address phase, exactly one strobe goes low: ior_n for an I/O read (req_mem=0, req_write=0), iow_n for an I/O write, memr_n for a memory read and memw_n for a memory write. With iochrdy high it stays low for exactly T_STROBE cycles. The other three strobes stay high.
- R5: If iochrdy is held low and is first seen high at the edge that ends strobe cycle K, the strobe lasts max(T_STROBE, K) cycles.
- R6: After the strobe is released, the address is held for exactly T_HOLD cycles. Then rsp_done is 1 for one cycle, with rsp_rdata valid, and req_ready returns to 1 in that same cycle.
- R7: sa equals req_addr during the whole cycle, with two exceptions: bits 23..16 are forced to 0 for I/O space, and bit 0 is forced to 0 for a wide-alias word access.
- R8: Narrow alias (req_wide=0): req_word is ignored and the access is one byte on the low lane. sbhe_n stays 1, a write drives d_out[7:0]=req_wdata[7:0] with only d_oe_lo set, and a read returns {8'h00, d_in[7:0]}.
- R9: Wide alias byte access (req_wide=1, req_word=0): an even address behaves as in R8. An odd address uses the high lane: sbhe_n is 0, a write drives d_out[15:8]=req_wdata[7:0] with only d_oe_hi set, and a read returns {8'h00, d_in[15:8]}.
- R10: Wide alias word access (req_wide=1, req_word=1): sbhe_n is 0, a write drives d_out=req_wdata with both enables set, and a read returns d_in[15:0]. For a read, both enables are 0 in every mode.
- R11: From acceptance until the done cycle, req_ready is 0, and a req_valid with other request fields has no effect on the address, lanes or phase lengths.
- R12: aen is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_wide | input | 1 | 1 = wide alias, 0 = narrow alias |
| req_word | input | 1 | 1 = 16-bit access (wide alias only) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 2*BW | Write data, bytes in the low part |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 2*BW | Read data, valid with rsp_done |
| bus_clk | output | 1 | Bus clock, internal clock divided by CLK_DIV |
| bale | output | 1 | Address latch enable |
| sa | output | ADDR_W | Bus address |
| sbhe_n | output | 1 | High byte enable, active low |
| ior_n | output | 1 | I/O read strobe, active low |
| iow_n | output | 1 | I/O write strobe, active low |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| aen | output | 1 | Address enable, held low |
| d_out | output | 2*BW | Data driven to the bus |
| d_oe_lo | output | 1 | Drive enable for d_out[7:0] |
| d_oe_hi | output | 1 | Drive enable for d_out[15:8] |
| d_in | input | 2*BW | Data read from the bus |
| iochrdy | input | 1 | Target ready; low stretches the strobe |

## Verification
The request is accepted at one rising edge. bale rises in the next cycle and lasts T_SETUP cycles. The strobe then lasts max(T_STROBE, K) cycles, the hold lasts T_HOLD cycles, and rsp_done with read data follows in the next cycle. The bench samples on falling edges and counts how many samples fall in each phase, so each phase length is compared with its parameter rather than with an absolute time. The address, sbhe_n and lane values are compared on every busy sample. The ready line is released at the falling edge where strobe sample K is seen, so it is first visible at the edge that ends cycle K.

// File: rtl/isa_bus_pkg.sv
`timescale 1ns/1ps
package isa_bus_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_STRB = 2'd2,
    PH_HOLD = 2'd3
  } phase_e;

  typedef struct packed {
    logic lo;       // low lane carries data
    logic hi;       // high lane carries data
    logic hi_only;  // single byte moved to the high lane
  } lane_t;
endpackage

// File: rtl/isa_clkdiv.sv
`timescale 1ns/1ps
module isa_clkdiv #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst,
  output logic bus_clk
);
  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(HALF + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      bus_clk <= 1'b0;
    end else if (cnt == CW'(HALF - 1)) begin
      cnt     <= '0;
      bus_clk <= ~bus_clk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/isa_lane_steer.sv
`timescale 1ns/1ps
module isa_lane_steer
  import isa_bus_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic              wide_alias,
  input  logic              word,
  input  logic              addr_lsb,
  input  logic [2*BW-1:0]   wdata,
  output lane_t             plan,
  output logic [2*BW-1:0]   wlanes,
  input  lane_t             rplan,
  input  logic [2*BW-1:0]   din,
  output logic [2*BW-1:0]   rword
);
  localparam int DW = 2 * BW;

  // request side: pick the lanes from alias, size and byte position
  always_comb begin
    plan.hi_only = wide_alias && !word && addr_lsb;
    plan.hi      = wide_alias && (word || addr_lsb);
    plan.lo      = !plan.hi_only;
    if (plan.hi_only)
      wlanes = {wdata[BW-1:0], {BW{1'b0}}};
    else if (plan.hi)
      wlanes = wdata;
    else
      wlanes = {{BW{1'b0}}, wdata[BW-1:0]};
  end

  // return side: bring the lane(s) of the stored plan back to the word
  always_comb begin
    if (rplan.hi_only)
      rword = {{BW{1'b0}}, din[DW-1:BW]};
    else if (rplan.hi)
      rword = din;
    else
      rword = {{BW{1'b0}}, din[BW-1:0]};
  end
endmodule

// File: rtl/isa_phase_seq.sv
`timescale 1ns/1ps
module isa_phase_seq
  import isa_bus_pkg::*;
#(
  parameter int T_SETUP  = 9,
  parameter int T_STROBE = 24,
  parameter int T_HOLD   = 6
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   req_valid,
  input  logic   iochrdy,
  output phase_e phase,
  output logic   accept,
  output logic   capture,
  output logic   done
);
  localparam int TMAX = (T_SETUP > T_STROBE) ?
                        ((T_SETUP > T_HOLD) ? T_SETUP : T_HOLD) :
                        ((T_STROBE > T_HOLD) ? T_STROBE : T_HOLD);
  localparam int CW = $clog2(TMAX + 1);

  logic [CW-1:0] cnt;
  logic          strb_last;

  assign strb_last = (cnt == CW'(T_STROBE - 1));
  assign accept    = (phase == PH_IDLE) && req_valid;
  assign capture   = (phase == PH_STRB) && strb_last && iochrdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: if (req_valid) begin
          phase <= PH_ADDR;
          cnt   <= '0;
        end
        PH_ADDR: if (cnt == CW'(T_SETUP - 1)) begin
          phase <= PH_STRB;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        PH_STRB: if (strb_last) begin
          if (iochrdy) begin
            phase <= PH_HOLD;
            cnt   <= '0;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        PH_HOLD: if (cnt == CW'(T_HOLD - 1)) begin
          phase <= PH_IDLE;
          cnt   <= '0;
          done  <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/isa_bus_master.sv
`timescale 1ns/1ps
module isa_bus_master
  import isa_bus_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int IO_ADDR_W = 16,
  parameter int BW        = 8,
  parameter int CLK_DIV   = 12,
  parameter int T_SETUP   = 9,
  parameter int T_STROBE  = 24,
  parameter int T_HOLD    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_mem,
  input  logic              req_wide,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2*BW-1:0]   req_wdata,
  output logic              rsp_done,
  output logic [2*BW-1:0]   rsp_rdata,
  output logic              bus_clk,
  output logic              bale,
  output logic [ADDR_W-1:0] sa,
  output logic              sbhe_n,
  output logic              ior_n,
  output logic              iow_n,
  output logic              memr_n,
  output logic              memw_n,
  output logic              aen,
  output logic [2*BW-1:0]   d_out,
  output logic              d_oe_lo,
  output logic              d_oe_hi,
  input  logic [2*BW-1:0]   d_in,
  input  logic              iochrdy
);
  localparam int DW = 2 * BW;

  phase_e            phase;
  logic              accept, capture, busy, strobing;
  lane_t             plan_n, plan_q;
  logic [DW-1:0]     wl_n, rword;
  logic [ADDR_W-1:0] addr_n;
  logic              write_q, mem_q;

  isa_clkdiv #(.DIV(CLK_DIV)) u_div (
    .clk     (clk),
    .rst     (rst),
    .bus_clk (bus_clk)
  );

  isa_phase_seq #(
    .T_SETUP  (T_SETUP),
    .T_STROBE (T_STROBE),
    .T_HOLD   (T_HOLD)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .iochrdy   (iochrdy),
    .phase     (phase),
    .accept    (accept),
    .capture   (capture),
    .done      (rsp_done)
  );

  isa_lane_steer #(.BW(BW)) u_lane (
    .wide_alias (req_wide),
    .word       (req_word),
    .addr_lsb   (req_addr[0]),
    .wdata      (req_wdata),
    .plan       (plan_n),
    .wlanes     (wl_n),
    .rplan      (plan_q),
    .din        (d_in),
    .rword      (rword)
  );

  // address as seen by the bus: I/O window trimmed, word address aligned
  always_comb begin
    addr_n = req_addr;
    if (!req_mem)
      addr_n[ADDR_W-1:IO_ADDR_W] = '0;
    if (req_wide && req_word)
      addr_n[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sa        <= '0;
      plan_q    <= '0;
      write_q   <= 1'b0;
      mem_q     <= 1'b0;
      d_out     <= '0;
      rsp_rdata <= '0;
    end else begin
      if (accept) begin
        sa      <= addr_n;
        plan_q  <= plan_n;
        write_q <= req_write;
        mem_q   <= req_mem;
        d_out   <= req_write ? wl_n : '0;
      end
      if (capture && !write_q)
        rsp_rdata <= rword;
    end
  end

  assign busy      = (phase != PH_IDLE);
  assign strobing  = (phase == PH_STRB);
  assign req_ready = !busy;
  assign bale      = (phase == PH_ADDR);
  assign sbhe_n    = !(busy && plan_q.hi);
  assign ior_n     = !(strobing && !mem_q && !write_q);
  assign iow_n     = !(strobing && !mem_q &&  write_q);
  assign memr_n    = !(strobing &&  mem_q && !write_q);
  assign memw_n    = !(strobing &&  mem_q &&  write_q);
  assign d_oe_lo   = busy && write_q && plan_q.lo;
  assign d_oe_hi   = busy && write_q && plan_q.hi;
  assign aen       = 1'b0;
endmodule

// File: rtl/isa_bus_master_chk.sv
`timescale 1ns/1ps
module isa_bus_master_chk #(
  parameter int ADDR_W    = 24,
  parameter int IO_ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_done,
  input logic              bale,
  input logic [ADDR_W-1:0] sa,
  input logic              sbhe_n,
  input logic              ior_n,
  input logic              iow_n,
  input logic              memr_n,
  input logic              memw_n,
  input logic              d_oe_hi,
  input logic              iochrdy
);
  logic any_strb, io_strb, wr_strb;
  assign any_strb = !(ior_n && iow_n && memr_n && memw_n);
  assign io_strb  = !ior_n || !iow_n;
  assign wr_strb  = !iow_n || !memw_n;

  p_single_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    $countones({~ior_n, ~iow_n, ~memr_n, ~memw_n}) <= 1);

  p_bale_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    bale |-> !any_strb);

  p_wait_extends_r5: assert property (@(posedge clk) disable iff (rst)
    (any_strb && !iochrdy) |=> any_strb);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  p_addr_stable_r11: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && $past(!req_ready)) |-> $stable(sa));

  p_io_window_r7: assert property (@(posedge clk) disable iff (rst)
    io_strb |-> (sa[ADDR_W-1:IO_ADDR_W] == '0));

  p_sbhe_lane_r9: assert property (@(posedge clk) disable iff (rst)
    wr_strb |-> (sbhe_n == !d_oe_hi));
endmodule

bind isa_bus_master isa_bus_master_chk #(
  .ADDR_W    (ADDR_W),
  .IO_ADDR_W (IO_ADDR_W)
) u_chk (.*);

// File: tb/isa_bus_master_test.sv
`timescale 1ns/1ps
module isa_bus_master_test;
  localparam int TS = 3, TW = 4, TH = 2, DIV = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0;
  logic req_wide = 1'b0, req_word = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic iochrdy = 1'b1;
  logic req_ready, rsp_done, bus_clk, bale, sbhe_n;
  logic ior_n, iow_n, memr_n, memw_n, aen, d_oe_lo, d_oe_hi;
  logic [15:0] rsp_rdata, d_out, d_in;
  logic [23:0] sa;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  // target model: read data derived from the address on the bus
  assign d_in = {sa[7:0] ^ 8'h5A, sa[7:0] ^ 8'hC3};

  isa_bus_master #(
    .T_SETUP(TS), .T_STROBE(TW), .T_HOLD(TH), .CLK_DIV(DIV)
  ) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_mem(req_mem), .req_wide(req_wide),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_clk(bus_clk),
    .bale(bale), .sa(sa), .sbhe_n(sbhe_n), .ior_n(ior_n), .iow_n(iow_n),
    .memr_n(memr_n), .memw_n(memw_n), .aen(aen), .d_out(d_out),
    .d_oe_lo(d_oe_lo), .d_oe_hi(d_oe_hi), .d_in(d_in), .iochrdy(iochrdy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic run(input bit mem, input bit wr, input bit wide, input bit word,
                     input logic [23:0] addr, input logic [15:0] wdata,
                     input int kwait, input bit noise);
    logic [23:0] exp_sa;
    logic [15:0] exp_rd;
    logic [7:0]  lo_b, hi_b;
    bit hi_only, both, uses_hi, seen_strb;
    int nb, ns, nh, bad_sa, bad_sbhe, bad_data, bad_rdy, bad_other, bad_aen, bad_order, guard;
    string ltag;
    exp_sa = mem ? addr : {8'h00, addr[15:0]};
    if (wide && word) exp_sa[0] = 1'b0;
    hi_only = wide && !word && addr[0];
    both    = wide && word;
    uses_hi = hi_only || both;
    lo_b = exp_sa[7:0] ^ 8'hC3;
    hi_b = exp_sa[7:0] ^ 8'h5A;
    exp_rd = hi_only ? {8'h00, hi_b} : (both ? {hi_b, lo_b} : {8'h00, lo_b});
    ltag = wide ? (word ? "R10 word lanes" : "R9 wide byte lanes") : "R8 narrow lanes";
    nb = 0; ns = 0; nh = 0; bad_sa = 0; bad_sbhe = 0; bad_data = 0;
    bad_rdy = 0; bad_other = 0; bad_aen = 0; bad_order = 0; guard = 0;
    seen_strb = 0;

    @(negedge clk);
    chk("R11 idle ready before request", req_ready, 1);
    req_mem = mem; req_write = wr; req_wide = wide; req_word = word;
    req_addr = addr; req_wdata = wdata; req_valid = 1'b1;
    iochrdy = (kwait == 0);
    forever begin
      @(negedge clk);
      guard++;
      if (noise) begin
        req_addr = ~addr; req_wdata = ~wdata; req_word = ~word;
        req_wide = ~wide; req_write = ~wr; req_mem = ~mem;
      end else begin
        req_valid = 1'b0;
      end
      if (rsp_done || guard > 200) break;
      if (sa !== exp_sa) bad_sa++;
      if (sbhe_n !== !uses_hi) bad_sbhe++;
      if (req_ready !== 1'b0) bad_rdy++;
      if (aen !== 1'b0) bad_aen++;
      if (bale) begin
        nb++;
        if (seen_strb) bad_order++;
        if ({ior_n, iow_n, memr_n, memw_n} !== 4'hF) bad_order++;
      end else if ({ior_n, iow_n, memr_n, memw_n} !== 4'hF) begin
        seen_strb = 1;
        case ({mem, wr})
          2'b00: if ({ior_n, iow_n, memr_n, memw_n} === 4'b0111) ns++; else bad_other++;
          2'b01: if ({ior_n, iow_n, memr_n, memw_n} === 4'b1011) ns++; else bad_other++;
          2'b10: if ({ior_n, iow_n, memr_n, memw_n} === 4'b1101) ns++; else bad_other++;
          default: if ({ior_n, iow_n, memr_n, memw_n} === 4'b1110) ns++; else bad_other++;
        endcase
        if (ns == kwait) iochrdy = 1'b1;
        if (wr) begin
          if (d_oe_lo !== !hi_only || d_oe_hi !== uses_hi) bad_data++;
          if (both && d_out !== wdata) bad_data++;
          if (hi_only && d_out[15:8] !== wdata[7:0]) bad_data++;
          if (!uses_hi && d_out[7:0] !== wdata[7:0]) bad_data++;
        end else if (d_oe_lo || d_oe_hi) begin
          bad_data++;
        end
      end else if (seen_strb) begin
        nh++;
      end
    end
    req_valid = 1'b0;
    iochrdy = 1'b1;
    chk("R6 done reached", rsp_done, 1);
    chk("R6 ready in done cycle", req_ready, 1);
    chk("R3 address phase length", nb, TS);
    chk("R3 order of bale and strobe", bad_order, 0);
    chk(kwait > 0 ? "R5 stretched strobe length" : "R4 strobe length", ns,
        (kwait > TW) ? kwait : TW);
    chk("R4 other strobes high", bad_other, 0);
    chk("R6 hold length", nh, TH);
    chk("R7 bus address", bad_sa, 0);
    chk({ltag, " sbhe_n"}, bad_sbhe, 0);
    chk({ltag, " data out"}, bad_data, 0);
    chk(noise ? "R11 busy ignores request" : "R11 ready low while busy", bad_rdy, 0);
    chk("R12 aen low", bad_aen, 0);
    if (!wr) chk({ltag, " read data"}, rsp_rdata, exp_rd);
    @(negedge clk);
    chk("R6 done one cycle", rsp_done, 0);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL R6 watchdog: actual hung expected completion");
    summary();
    $finish;
  end

  initial begin
    int rises, highs, last_rise, bad_gap;
    logic prev;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", req_ready, 1);
    chk("R1 bale in reset", bale, 0);
    chk("R1 strobes in reset", {ior_n, iow_n, memr_n, memw_n}, 4'hF);
    chk("R1 sbhe_n in reset", sbhe_n, 1);
    chk("R1 done in reset", rsp_done, 0);
    chk("R1 enables in reset", {d_oe_lo, d_oe_hi}, 0);
    chk("R12 aen in reset", aen, 0);
    chk("R2 bus clock low in reset", bus_clk, 0);
    rst = 1'b0;
    // bus clock: samples 1..48 after the first active edge
    rises = 0; highs = 0; last_rise = -1; bad_gap = 0; prev = 1'b0;
    for (int i = 1; i <= 48; i++) begin
      @(negedge clk);
      if (bus_clk) highs++;
      if (bus_clk && !prev) begin
        if (last_rise < 0) chk("R2 first rise", i, DIV / 2);
        else if (i - last_rise != DIV) bad_gap++;
        last_rise = i;
        rises++;
      end
      prev = bus_clk;
    end
    chk("R2 rising edges", rises, 4);
    chk("R2 high samples", highs, 24);
    chk("R2 period", bad_gap, 0);
    chk("R1 idle after reset", {req_ready, rsp_done, bale}, 3'b100);

    // sweep of space, direction, alias, size and low address bits
    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 2; w++)
        for (int a = 0; a < 2; a++)
          for (int s = 0; s < 2; s++)
            for (int l = 0; l < 4; l++) begin
              logic [23:0] ad;
              int idx;
              idx = ((m * 2 + w) * 2 + a) * 8 + s * 4 + l;
              ad = 24'h9E7B40 + 24'(idx) * 24'h010305;
              ad[1:0] = 2'(l);
              run(m[0], w[0], a[0], s[0], ad, 16'h6D00 ^ (16'(idx) * 16'h0123), 0, 0);
            end

    // ready stretching, shorter and longer than the strobe phase
    for (int k = 1; k <= 8; k++) begin
      run(k[0], 1'b0, 1'b1, k[1], 24'h3A5501 + 24'(k), 16'h0, k, 0);
      run(~k[0], 1'b1, k[1], 1'b1, 24'h71C6F2 + 24'(k), 16'hB4E1 + 16'(k), k, 0);
    end

    // requests held during a busy cycle
    run(1'b1, 1'b1, 1'b1, 1'b0, 24'hFEDC35, 16'h00A7, 0, 1);
    run(1'b0, 1'b0, 1'b1, 1'b1, 24'h12ABCD, 16'h0000, 6, 1);
    run(1'b1, 1'b0, 1'b0, 1'b1, 24'h800003, 16'h0000, 0, 1);

    summary();
    $finish;
  end
endmodule